// File: doc/BRIEF.md
# Write-Completion Acknowledge Polling Master

This block sits on the host side of a two-wire serial bus. It waits for an attached serial memory to finish its internal programming cycle. While that cycle runs, the memory does not answer its own address. On each poll request the block therefore tries a series of attempts. Each attempt forms a START condition, shifts out the 7-bit device address with a write direction bit, and samples the acknowledge slot.

An unanswered attempt is closed with a STOP, and the block tries again. When the device answers, the block does one of two things:

- If the caller flagged that the next operation is a write, the block keeps the transaction open and sends the byte address. It then parks the bus with SCL held low until the caller releases it.
- Otherwise it closes with a STOP and reports that the device is ready.

A programmable attempt limit ends a poll that never gets an answer and raises a timeout result. Bus timing comes from a divider parameter. Every bit takes four phases of `DIV` system clocks each.

Top module: `ack_poll_master`

## Requirements
- R1: Out of reset, scl_o and sda_o are both 1 (released), and busy_o, hold_o and done_o are 0.
- R2: Each attempt is a START (sda falls while scl is high), then the 8 bits {dev_addr_i, 1'b0} MSB first, then a ninth clock in which sda_i is sampled as the acknowledge (0 = ACK). The inputs are captured when the request is accepted.
- R3: A NACK on the address closes the attempt with a STOP (sda rises while scl is high), and a new START follows. With k NACKs before the device answers, there are k+1 attempts.
- R4: When the address is acknowledged and next_wr_i was 0, the block issues a STOP and then pulses done_o with ready_o=1, timeout_o=0 and hold_o=0.
- R5: When the address is acknowledged and next_wr_i was 1, the block sends byte_addr_i MSB first with no STOP before it. If that byte is acknowledged, done_o pulses with ready_o=1 and hold_o=1, and SCL stays low. A release_i pulse while holding issues one STOP and clears hold_o.
- R6: With try_limit_i = N ≥ 1, after N unanswered attempts the block issues a STOP and pulses done_o with timeout_o=1 and ready_o=0. With try_limit_i = 0 there is no limit.
- R7: If the byte address is not acknowledged, the block issues a STOP and pulses done_o with ready_o=0, timeout_o=0 and hold_o=0.
- R8: SCL and SDA never change in the same clock cycle. Within a transaction, every SCL high time is 2*DIV clocks.
- R9: start_i is ignored while busy_o or hold_o is high. done_o lasts one cycle with busy_o low. An accepted start_i raises busy_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Poll request pulse |
| dev_addr_i | input | 7 | Device address |
| byte_addr_i | input | 8 | Byte address sent when the next operation is a write |
| next_wr_i | input | 1 | 1 = keep the bus and send the byte address after the ACK |
| try_limit_i | input | TRY_W | Maximum number of attempts, 0 = unlimited |
| release_i | input | 1 | Close a held transaction with a STOP |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_o | output | 1 | SCL drive (1 = released) |
| sda_o | output | 1 | SDA drive (1 = released) |
| busy_o | output | 1 | Poll or STOP in progress |
| hold_o | output | 1 | Transaction held open after the byte address |
| done_o | output | 1 | One-cycle result strobe |
| ready_o | output | 1 | Device answered, result valid with done_o |
| timeout_o | output | 1 | Attempt limit reached, result valid with done_o |

## Verification
No poll result has a fixed latency. It depends on how many attempts the device refuses, and each bit costs 4*DIV clocks plus two handshake cycles. The bench therefore waits, under a bound, for the done_o strobe and samples ready_o, timeout_o and hold_o on the falling clock edge of that same cycle. That is where the registered strobe and the results are valid together. The bus-side results are counted by a device model:

- START and STOP conditions
- captured address bytes
- SCL high times

These counts are compared after done_o, because the final STOP's rising SDA edge lands before the strobe. After a release_i pulse, the STOP count is checked once busy_o and hold_o have both fallen.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } bus_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_START = 4'd1,
    ST_ADDR  = 4'd2,
    ST_AACK  = 4'd3,
    ST_RSTOP = 4'd4,
    ST_BADDR = 4'd5,
    ST_BACK  = 4'd6,
    ST_FSTOP = 4'd7,
    ST_HOLD  = 4'd8,
    ST_XSTOP = 4'd9
  } seq_state_e;
endpackage

// File: rtl/ackpoll_tick.sv
module ackpoll_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else if (tick_o)         cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ackpoll_bit_eng.sv
module ackpoll_bit_eng
  import ackpoll_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_valid_i,
  input  bus_cmd_e cmd_i,
  input  logic     bit_i,
  input  logic     sda_i,
  output logic     done_o,
  output logic     rx_o,
  output logic     scl_o,
  output logic     sda_o
);
  logic       active_q;
  logic [1:0] phase_q;
  bus_cmd_e   cmd_q;
  logic       bit_q;
  logic       tick;
  logic       accept;

  assign accept = cmd_valid_i && !active_q;

  ackpoll_tick #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (active_q),
    .tick_o (tick)
  );

  // {scl, sda} for each phase; edges on SDA with SCL high only in START/STOP
  function automatic logic [1:0] pins(bus_cmd_e c, logic [1:0] ph, logic b);
    logic [1:0] r;
    unique case (c)
      BC_START: r = (ph == 2'd0 || ph == 2'd1) ? 2'b11 :
                    (ph == 2'd2) ? 2'b10 : 2'b00;
      BC_STOP:  r = (ph == 2'd0) ? 2'b00 :
                    (ph == 2'd1) ? 2'b10 : 2'b11;
      BC_WRITE: r = {(ph == 2'd1 || ph == 2'd2), b};
      default:  r = {(ph == 2'd1 || ph == 2'd2), 1'b1};
    endcase
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      cmd_q    <= BC_STOP;
      bit_q    <= 1'b1;
      done_o   <= 1'b0;
      rx_o     <= 1'b1;
      scl_o    <= 1'b1;
      sda_o    <= 1'b1;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        active_q       <= 1'b1;
        phase_q        <= 2'd0;
        cmd_q          <= cmd_i;
        bit_q          <= bit_i;
        {scl_o, sda_o} <= pins(cmd_i, 2'd0, bit_i);
      end else if (tick) begin
        if (phase_q == 2'd2 && cmd_q == BC_READ) rx_o <= sda_i;
        if (phase_q == 2'd3) begin
          active_q <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          phase_q        <= phase_q + 2'd1;
          {scl_o, sda_o} <= pins(cmd_q, phase_q + 2'd1, bit_q);
        end
      end
    end
  end
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned TRY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic [BYTE_W-1:0] byte_addr_i,
  input  logic              next_wr_i,
  input  logic [TRY_W-1:0]  try_limit_i,
  input  logic              release_i,
  input  logic              eng_done_i,
  input  logic              eng_rx_i,
  output logic              cmd_valid_o,
  output bus_cmd_e          cmd_o,
  output logic              bit_o,
  output logic              busy_o,
  output logic              hold_o,
  output logic              done_o,
  output logic              ready_o,
  output logic              timeout_o
);
  localparam int unsigned SH_W = ADDR_W + 1;
  localparam int unsigned CNT_W = $clog2(SH_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SH_W - 1);

  seq_state_e        state_q;
  logic              pend_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TRY_W-1:0]  tries_q;
  logic [TRY_W-1:0]  lim_q;
  logic [ADDR_W-1:0] dev_q;
  logic [BYTE_W-1:0] baddr_q;
  logic              wr_q;
  logic              last_try;

  assign last_try = (lim_q != '0) &&
                    (({1'b0, tries_q} + 1'b1) == {1'b0, lim_q});

  always_comb begin
    unique case (state_q)
      ST_START:           cmd_o = BC_START;
      ST_ADDR, ST_BADDR:  cmd_o = BC_WRITE;
      ST_AACK, ST_BACK:   cmd_o = BC_READ;
      default:            cmd_o = BC_STOP;
    endcase
  end

  assign bit_o       = sh_q[SH_W-1];
  assign cmd_valid_o = (state_q != ST_IDLE) && (state_q != ST_HOLD) && !pend_q;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign hold_o      = (state_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      sh_q      <= '0;
      cnt_q     <= '0;
      tries_q   <= '0;
      lim_q     <= '0;
      dev_q     <= '0;
      baddr_q   <= '0;
      wr_q      <= 1'b0;
      done_o    <= 1'b0;
      ready_o   <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (cmd_valid_o)     pend_q <= 1'b1;
      else if (eng_done_i) pend_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start_i) begin
          dev_q     <= dev_addr_i;
          baddr_q   <= byte_addr_i;
          wr_q      <= next_wr_i;
          lim_q     <= try_limit_i;
          sh_q      <= {dev_addr_i, 1'b0};
          cnt_q     <= '0;
          tries_q   <= '0;
          ready_o   <= 1'b0;
          timeout_o <= 1'b0;
          state_q   <= ST_START;
        end
        ST_START: if (eng_done_i) state_q <= ST_ADDR;
        ST_ADDR, ST_BADDR: if (eng_done_i) begin
          sh_q <= sh_q << 1;
          if (cnt_q == LAST_BIT) begin
            cnt_q   <= '0;
            state_q <= (state_q == ST_ADDR) ? ST_AACK : ST_BACK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_AACK: if (eng_done_i) begin
          if (!eng_rx_i) begin
            if (wr_q) begin
              sh_q    <= SH_W'(baddr_q);
              state_q <= ST_BADDR;
            end else begin
              ready_o <= 1'b1;
              state_q <= ST_FSTOP;
            end
          end else if (last_try) begin
            timeout_o <= 1'b1;
            state_q   <= ST_FSTOP;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= ST_RSTOP;
          end
        end
        ST_RSTOP: if (eng_done_i) begin
          sh_q    <= {dev_q, 1'b0};
          state_q <= ST_START;
        end
        ST_BACK: if (eng_done_i) begin
          if (!eng_rx_i) begin
            ready_o <= 1'b1;
            done_o  <= 1'b1;
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_FSTOP;
          end
        end
        ST_FSTOP: if (eng_done_i) begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_HOLD: if (release_i) state_q <= ST_XSTOP;
        ST_XSTOP: if (eng_done_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ack_poll_master.sv
module ack_poll_master
  import ackpoll_pkg::*;
#(
  parameter int unsigned DIV   = 4,
  parameter int unsigned TRY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [7:0]       byte_addr_i,
  input  logic             next_wr_i,
  input  logic [TRY_W-1:0] try_limit_i,
  input  logic             release_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             busy_o,
  output logic             hold_o,
  output logic             done_o,
  output logic             ready_o,
  output logic             timeout_o
);
  logic     cmd_valid;
  bus_cmd_e cmd;
  logic     cmd_bit;
  logic     eng_done;
  logic     eng_rx;

  ackpoll_seq #(.ADDR_W(7), .TRY_W(TRY_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dev_addr_i  (dev_addr_i),
    .byte_addr_i (byte_addr_i),
    .next_wr_i   (next_wr_i),
    .try_limit_i (try_limit_i),
    .release_i   (release_i),
    .eng_done_i  (eng_done),
    .eng_rx_i    (eng_rx),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd),
    .bit_o       (cmd_bit),
    .busy_o      (busy_o),
    .hold_o      (hold_o),
    .done_o      (done_o),
    .ready_o     (ready_o),
    .timeout_o   (timeout_o)
  );

  ackpoll_bit_eng #(.DIV(DIV)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .bit_i       (cmd_bit),
    .sda_i       (sda_i),
    .done_o      (eng_done),
    .rx_o        (eng_rx),
    .scl_o       (scl_o),
    .sda_o       (sda_o)
  );
endmodule

// File: rtl/ack_poll_master_chk.sv
module ack_poll_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic scl_o,
  input logic sda_o,
  input logic busy_o,
  input logic hold_o,
  input logic done_o,
  input logic ready_o,
  input logic timeout_o
);
  AST_NO_SIMUL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o != $past(scl_o)) |-> (sda_o == $past(sda_o))); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9

  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !hold_o) |=> busy_o); // R9

  AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(ready_o && timeout_o)); // R6

  AST_HOLD_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (!scl_o && ready_o)); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !hold_o) |-> (scl_o && sda_o)); // R4
endmodule

bind ack_poll_master ack_poll_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .scl_o     (scl_o),
  .sda_o     (sda_o),
  .busy_o    (busy_o),
  .hold_o    (hold_o),
  .done_o    (done_o),
  .ready_o   (ready_o),
  .timeout_o (timeout_o)
);

// File: tb/ack_poll_master_test.sv
`timescale 1ns/1ps
module ack_poll_master_test;
  localparam int DIV = 4;

  typedef struct packed {
    logic [3:0] nacks;
    logic       wr;
    logic [7:0] lim;
    logic [6:0] dev;
    logic [7:0] baddr;
    logic       nack_b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 8'd3, 7'h50, 8'h00, 1'b0},
    '{4'd2, 1'b0, 8'd5, 7'h2A, 8'h00, 1'b0},
    '{4'd4, 1'b0, 8'd3, 7'h51, 8'h00, 1'b0},
    '{4'd1, 1'b1, 8'd4, 7'h53, 8'hC5, 1'b0},
    '{4'd3, 1'b0, 8'd0, 7'h11, 8'h00, 1'b0},
    '{4'd0, 1'b1, 8'd2, 7'h6E, 8'h3C, 1'b1},
    '{4'd2, 1'b1, 8'd3, 7'h55, 8'h81, 1'b0},
    '{4'd3, 1'b1, 8'd3, 7'h57, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic [7:0] byte_addr_i = '0;
  logic next_wr_i = 1'b0;
  logic [7:0] try_limit_i = '0;
  logic release_i = 1'b0;
  logic scl_o, sda_o, busy_o, hold_o, done_o, ready_o, timeout_o;
  logic slv_sda = 1'b1;
  wire  sda_bus = sda_o & slv_sda;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ack_poll_master #(.DIV(DIV), .TRY_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dev_addr_i(dev_addr_i),
    .byte_addr_i(byte_addr_i), .next_wr_i(next_wr_i), .try_limit_i(try_limit_i),
    .release_i(release_i), .sda_i(sda_bus), .scl_o(scl_o), .sda_o(sda_o),
    .busy_o(busy_o), .hold_o(hold_o), .done_o(done_o), .ready_o(ready_o),
    .timeout_o(timeout_o)
  );

  // device model
  int       cur_nacks = 0;
  logic     cur_nack_b = 1'b0;
  logic [7:0] exp_addr = '0;
  int       n_start = 0, n_stop = 0, n_addr = 0, addr_bad = 0;
  int       n_baddr = 0;
  logic [7:0] baddr_seen = '0;
  int       scl_bad = 0;
  int       bitcnt = 0, byte_idx = 0;
  logic     in_txn = 1'b0, ack_ph = 1'b0, rise_ok = 1'b0;
  logic [7:0] sh = '0;
  int       cyc = 0, rise_cyc = 0;

  always @(posedge clk) cyc++;

  always @(negedge sda_bus) if (scl_o === 1'b1) begin
    n_start++; in_txn = 1'b1; bitcnt = 0; byte_idx = 0; ack_ph = 1'b0;
  end

  always @(posedge sda_bus) if (scl_o === 1'b1 && in_txn) begin
    n_stop++; in_txn = 1'b0; rise_ok = 1'b0;
  end

  always @(posedge scl_o) begin
    rise_ok = in_txn; rise_cyc = cyc;
    if (in_txn && bitcnt < 8) begin
      sh = {sh[6:0], sda_bus};
      bitcnt++;
      if (bitcnt == 8) begin
        if (byte_idx == 0) begin
          n_addr++;
          if (sh !== exp_addr) addr_bad++;
        end else begin
          n_baddr++; baddr_seen = sh;
        end
      end
    end
  end

  always @(negedge scl_o) begin
    if (rise_ok && (cyc - rise_cyc) != 2*DIV) scl_bad++;
    rise_ok = 1'b0;
    if (in_txn && bitcnt == 8 && !ack_ph) begin
      ack_ph = 1'b1;
      if (byte_idx == 0) slv_sda = (n_addr > cur_nacks) ? 1'b0 : 1'b1;
      else               slv_sda = cur_nack_b ? 1'b1 : 1'b0;
    end else if (ack_ph) begin
      ack_ph = 1'b0; slv_sda = 1'b1; bitcnt = 0; byte_idx++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    n_start = 0; n_stop = 0; n_addr = 0; addr_bad = 0; n_baddr = 0;
    baddr_seen = '0; scl_bad = 0;
  endtask

  task automatic wait_done(output logic ok);
    int w = 0;
    ok = 1'b1;
    while (done_o !== 1'b1 && w < 20000) begin @(negedge clk); w++; end
    if (w >= 20000) begin
      ok = 1'b0; n_tests++; n_fail++;
      $display("FAIL R9: watchdog, done_o never rose");
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input logic poke);
    int   attempts;
    logic to_e, rdy_e, hold_e, ok;
    to_e     = (v.lim != 0) && (v.nacks >= v.lim);
    attempts = to_e ? int'(v.lim) : int'(v.nacks) + 1;
    rdy_e    = !to_e && !(v.wr && v.nack_b);
    hold_e   = !to_e && v.wr && !v.nack_b;
    clear_model();
    cur_nacks = v.nacks; cur_nack_b = v.nack_b; exp_addr = {v.dev, 1'b0};
    @(negedge clk);
    dev_addr_i = v.dev; byte_addr_i = v.baddr; next_wr_i = v.wr; try_limit_i = v.lim;
    pulse_start();
    if (poke) begin // R9: second request mid-run with new inputs
      repeat (40) @(negedge clk);
      dev_addr_i = 7'h00; next_wr_i = ~v.wr;
      pulse_start();
    end
    wait_done(ok);
    if (!ok) return;
    chk("R4 ready_o", ready_o, rdy_e);
    chk("R6 timeout_o", timeout_o, to_e);
    chk("R5 hold_o", hold_o, hold_e);
    chk("R9 busy_o at done", busy_o, 1'b0);
    chk("R3 START count", n_start, attempts);
    chk("R2 address bytes", n_addr, attempts);
    chk("R2 address value", addr_bad, 0);
    chk("R3 STOP count", n_stop, hold_e ? attempts - 1 : attempts);
    chk("R5 byte address count", n_baddr, (!to_e && v.wr) ? 1 : 0);
    if (!to_e && v.wr) chk("R5 byte address value", baddr_seen, v.baddr);
    if (v.wr && v.nack_b) chk("R7 no hold after byte NACK", hold_o, 1'b0);
    @(negedge clk);
    chk("R9 done one cycle", done_o, 1'b0);
    if (hold_e) begin
      int w = 0;
      repeat (30) @(negedge clk);
      chk("R5 SCL held low", scl_o, 1'b0);
      @(negedge clk); release_i = 1'b1;
      @(negedge clk); release_i = 1'b0;
      while ((busy_o || hold_o) && w < 2000) begin @(negedge clk); w++; end
      chk("R5 hold_o after release", hold_o, 1'b0);
      chk("R5 STOP after release", n_stop, attempts);
    end
    chk("R8 SCL high time", scl_bad, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R9: global watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    chk("R1 scl_o in reset", scl_o, 1'b1);
    chk("R1 sda_o in reset", sda_o, 1'b1);
    chk("R1 busy_o in reset", busy_o, 1'b0);
    chk("R1 done_o in reset", done_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 hold_o after reset", hold_o, 1'b0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], (i == 1) || (i == 3));

    // R9: start ignored while holding
    clear_model();
    cur_nacks = 0; cur_nack_b = 1'b0; exp_addr = {7'h22, 1'b0};
    @(negedge clk);
    dev_addr_i = 7'h22; byte_addr_i = 8'h5A; next_wr_i = 1'b1; try_limit_i = 8'd1;
    pulse_start();
    wait_done(ok);
    if (ok) begin
      chk("R5 hold for limit one", hold_o, 1'b1);
      pulse_start();
      repeat (60) @(negedge clk);
      chk("R9 start ignored in hold: hold_o", hold_o, 1'b1);
      chk("R9 start ignored in hold: START count", n_start, 1);
      @(negedge clk); release_i = 1'b1;
      @(negedge clk); release_i = 1'b0;
      repeat (40) @(negedge clk);
      chk("R5 released", hold_o | busy_o, 1'b0);
    end

    // R1: reset in the middle of a poll
    clear_model();
    cur_nacks = 9; exp_addr = {7'h33, 1'b0};
    dev_addr_i = 7'h33; next_wr_i = 1'b0; try_limit_i = 8'd0;
    pulse_start();
    repeat (100) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 scl_o after mid-run reset", scl_o, 1'b1);
    chk("R1 sda_o after mid-run reset", sda_o, 1'b1);
    chk("R1 busy_o after mid-run reset", busy_o, 1'b0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule